// File: doc/BRIEF.md
# Line Strobe Latch and Drive Timing Controller

This block sequences each display line at the output side of a column driver. A line strobe moves the captured row of gray-scale codes into an output latch. While the strobe is high every channel is held in high impedance. When the strobe falls the outputs are enabled, and a high-drive window of a selectable number of clocks starts. A polarity input is captured when the strobe is first seen high. From it each channel gets its voltage-reference set, with odd and even channels on opposite sets.

The strobe is sampled on rising clock edges. The code transfer itself lands on the falling clock edge that follows the first rising edge that sees the strobe high. The block flags a strobe that is too short to complete a transfer cleanly. It also lets a new strobe cut a running drive window short. The analog converter and the output amplifiers are outside this block. The block reports their control through an enable flag, a high-drive flag and one polarity-select bit per channel.

Top module: `lineStrobeDriver`

## Requirements
- R1: After reset, outEnable, highDrive and protoErr are 0, latchedCodes is all zero, and chanPolSel shows the polarity-0 assignment.
- R2: The first rising edge that samples strobe high arms one transfer, and latchedCodes takes lineData at the falling clock edge right after it. Changes to lineData while the strobe stays high are not captured.
- R3: outEnable is 0 after every rising edge that samples strobe high, and it drops at the first such edge.
- R4: At the first rising edge that samples strobe low after a high sample, outEnable becomes 1.
- R5: If longDriveN is 1 at that falling-strobe edge, highDrive becomes 1 at the same edge as outEnable and stays 1 for exactly SHORT_WIN rising edges.
- R6: If longDriveN is 0 at that edge, highDrive stays 1 for exactly LONG_WIN rising edges.
- R7: longDriveN is only taken at the falling-strobe edge. Changing it during a running window does not change the window's length.
- R8: chanPolSel[i] = 1 selects the upper reference set. With the captured polarity at 0, channels with an even index i (odd-numbered channels counted from 1) select upper and odd indices select lower. With polarity 1 the assignment is swapped. Polarity is taken only at the edge that starts a transfer.
- R9: A strobe sampled high during a running drive window clears highDrive and outEnable at that same edge.
- R10: At each falling-strobe edge, protoErr is set to 1 if the strobe was sampled high on fewer than two rising edges, and to 0 otherwise.
- R11: Outside a transfer, latchedCodes and chanPolSel hold their values whatever lineData and polarity do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift/line clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Line strobe |
| polarity | input | 1 | Polarity for the coming line |
| longDriveN | input | 1 | 1 = short drive window, 0 = long drive window |
| lineData | input | NUM_CH*CODE_W | Captured line codes, channel 0 in the low bits |
| latchedCodes | output | NUM_CH*CODE_W | Latched codes driven to the converters |
| chanPolSel | output | NUM_CH | Per-channel reference select, 1 = upper set |
| outEnable | output | 1 | 0 = all outputs high impedance |
| highDrive | output | 1 | Amplifier high-drive window |
| protoErr | output | 1 | Last strobe was shorter than two samples |

## Verification
The bench builds the block with 8 channels of 6-bit codes and windows of 4 and 8 clocks. The short windows let it count every edge of both drive lengths in full. The short windows also let it interrupt a window, change the select in the middle of one, and follow several lines in a row within a short run. Eight channels are enough to cover both polarity assignments and a full row comparison in one 48-bit value, while the structure per channel stays the same as at full width.

// File: rtl/lineDrvPkg.sv
package lineDrvPkg;
  // Strobes from the sequencing control to the latch path and window timer.
  typedef struct packed {
    logic loadArm;    // one cycle: latch codes on the coming falling clock edge
    logic polCapture; // one cycle: take the polarity input now
    logic winStart;   // strobe fall detected: start the drive window
    logic winStop;    // strobe sampled high: kill window, force high impedance
    logic winLong;    // long-window request, valid with winStart
  } seqStrobes_t;
endpackage

// File: rtl/lineSeqCtrl.sv
module lineSeqCtrl
  import lineDrvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobe,
  input  logic        longDriveN,
  output seqStrobes_t seq,
  output logic        outEnable,
  output logic        protoErr
);
  logic       strbQ;
  logic       loadArmQ;
  logic [1:0] highCnt;
  logic       strbRise;
  logic       strbFall;

  assign strbRise = strobe & ~strbQ;
  assign strbFall = ~strobe & strbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbQ     <= 1'b0;
      loadArmQ  <= 1'b0;
      highCnt   <= 2'd0;
      outEnable <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      strbQ    <= strobe;
      loadArmQ <= strbRise;
      if (strbRise)
        highCnt <= 2'd1;
      else if (strobe && highCnt != 2'd2)
        highCnt <= highCnt + 2'd1;
      if (strobe)
        outEnable <= 1'b0;
      else if (strbFall)
        outEnable <= 1'b1;
      if (strbFall)
        protoErr <= (highCnt < 2'd2);
    end
  end

  always_comb begin
    seq.loadArm    = loadArmQ;
    seq.polCapture = strbRise;
    seq.winStart   = strbFall;
    seq.winStop    = strobe;
    seq.winLong    = ~longDriveN;
  end
endmodule

// File: rtl/driveWindowTimer.sv
module driveWindowTimer
  import lineDrvPkg::*;
#(
  parameter int SHORT_WIN = 64,
  parameter int LONG_WIN  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t seq,
  output logic        highDrive
);
  localparam int CNT_W = (LONG_WIN > 1) ? $clog2(LONG_WIN) : 1;
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_WIN - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_WIN - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highDrive <= 1'b0;
      remain    <= '0;
    end else if (seq.winStop) begin
      highDrive <= 1'b0;
      remain    <= '0;
    end else if (seq.winStart) begin
      highDrive <= 1'b1;
      remain    <= seq.winLong ? LONG_LOAD : SHORT_LOAD;
    end else if (highDrive) begin
      if (remain == '0)
        highDrive <= 1'b0;
      else
        remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/lineLatchPath.sv
module lineLatchPath
  import lineDrvPkg::*;
#(
  parameter int NUM_CH = 384,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              seq,
  input  logic                     polarity,
  input  logic [NUM_CH*CODE_W-1:0] lineData,
  output logic [NUM_CH*CODE_W-1:0] latchedCodes,
  output logic [NUM_CH-1:0]        chanPolSel
);
  logic polQ;

  // Transfer completes on the falling edge after the strobe was detected.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)
      latchedCodes <= '0;
    else if (seq.loadArm)
      latchedCodes <= lineData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      polQ <= 1'b0;
    else if (seq.polCapture)
      polQ <= polarity;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gPolSel
    if (ch % 2 == 0) begin : gOddPin
      assign chanPolSel[ch] = ~polQ;
    end else begin : gEvenPin
      assign chanPolSel[ch] = polQ;
    end
  end
endmodule

// File: rtl/lineStrobeDriver.sv
module lineStrobeDriver
  import lineDrvPkg::*;
#(
  parameter int NUM_CH    = 384,
  parameter int CODE_W    = 6,
  parameter int SHORT_WIN = 64,
  parameter int LONG_WIN  = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     strobe,
  input  logic                     polarity,
  input  logic                     longDriveN,
  input  logic [NUM_CH*CODE_W-1:0] lineData,
  output logic [NUM_CH*CODE_W-1:0] latchedCodes,
  output logic [NUM_CH-1:0]        chanPolSel,
  output logic                     outEnable,
  output logic                     highDrive,
  output logic                     protoErr
);
  seqStrobes_t seqCtl;

  lineSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .longDriveN(longDriveN),
    .seq(seqCtl), .outEnable(outEnable), .protoErr(protoErr)
  );

  driveWindowTimer #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) uTimer (
    .clk(clk), .rstN(rstN), .seq(seqCtl), .highDrive(highDrive)
  );

  lineLatchPath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .seq(seqCtl), .polarity(polarity),
    .lineData(lineData), .latchedCodes(latchedCodes), .chanPolSel(chanPolSel)
  );
endmodule

// File: rtl/lineDrvChecker.sv
module lineDrvChecker #(
  parameter int NUM_CH   = 384,
  parameter int CODE_W   = 6,
  parameter int LONG_WIN = 128
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     strobe,
  input logic                     outEnable,
  input logic                     highDrive,
  input logic                     protoErr,
  input logic [NUM_CH*CODE_W-1:0] latchedCodes,
  input logic [NUM_CH-1:0]        chanPolSel,
  input logic                     loadArm,
  input logic                     polCapture
);
  localparam int RUN_W = $clog2(LONG_WIN + 1) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      runLen <= '0;
    else
      runLen <= highDrive ? runLen + RUN_W'(1) : '0;
  end

  assert_hiz_while_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe) |-> !outEnable);

  assert_drive_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    highDrive |-> outEnable);

  assert_drive_starts_with_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highDrive) |-> $rose(outEnable));

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    highDrive |-> (runLen < RUN_W'(LONG_WIN)));

  assert_codes_only_on_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(latchedCodes) |-> loadArm);

  assert_pol_only_on_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanPolSel) |-> $past(polCapture));

  assert_err_only_at_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protoErr) |-> ($past(strobe, 2) && !$past(strobe)));
endmodule

bind lineStrobeDriver lineDrvChecker #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .LONG_WIN(LONG_WIN)
) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .outEnable(outEnable),
  .highDrive(highDrive), .protoErr(protoErr), .latchedCodes(latchedCodes),
  .chanPolSel(chanPolSel), .loadArm(seqCtl.loadArm), .polCapture(seqCtl.polCapture)
);

// File: tb/lineStrobeDriver_test.sv
module lineStrobeDriver_test;
  localparam int NUM_CH    = 8;
  localparam int CODE_W    = 6;
  localparam int SHORT_WIN = 4;
  localparam int LONG_WIN  = 8;
  localparam int DW        = NUM_CH * CODE_W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          strobe = 1'b0;
  logic          polarity = 1'b0;
  logic          longDriveN = 1'b1;
  logic [DW-1:0] lineData = '0;
  logic [DW-1:0] latchedCodes;
  logic [NUM_CH-1:0] chanPolSel;
  logic          outEnable, highDrive, protoErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  lineStrobeDriver #(.NUM_CH(NUM_CH), .CODE_W(CODE_W),
                     .SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) uut (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polarity(polarity),
    .longDriveN(longDriveN), .lineData(lineData), .latchedCodes(latchedCodes),
    .chanPolSel(chanPolSel), .outEnable(outEnable), .highDrive(highDrive),
    .protoErr(protoErr)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] rowPattern(int seed);
    logic [DW-1:0] r;
    for (int ch = 0; ch < NUM_CH; ch++)
      r[ch*CODE_W +: CODE_W] = CODE_W'((seed + ch * 7) & 63);
    return r;
  endfunction

  function automatic logic [NUM_CH-1:0] polPattern(logic pol);
    logic [NUM_CH-1:0] p;
    for (int ch = 0; ch < NUM_CH; ch++)
      p[ch] = (ch % 2 == 0) ? ~pol : pol;
    return p;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expectEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Counts rising edges with highDrive high; optionally flips the select mid-window.
  task automatic countWindow(output int n, input int flipAt);
    n = 0;
    while (highDrive && n < 1000) begin
      n++;
      if (n == flipAt) longDriveN = ~longDriveN;
      tick();
    end
  endtask

  task automatic testReset();
    expectEq("R1", "outEnable", outEnable, 0);
    expectEq("R1", "highDrive", highDrive, 0);
    expectEq("R1", "protoErr", protoErr, 0);
    expectEq("R1", "latchedCodes", latchedCodes, 0);
    expectEq("R1", "chanPolSel", chanPolSel, polPattern(1'b0));
  endtask

  task automatic testShortWindow();
    int n;
    lineData = rowPattern(3); polarity = 1'b0; longDriveN = 1'b1;
    strobe = 1'b1;
    tick();
    expectEq("R3", "outEnable at strobe detect", outEnable, 0);
    #4;
    expectEq("R2", "codes after falling edge", latchedCodes, rowPattern(3));
    #4; // back at posedge+2 phase of the next cycle... re-align
    lineData = rowPattern(40);
    tick();
    expectEq("R3", "outEnable while strobe high", outEnable, 0);
    #4;
    expectEq("R2", "no recapture while high", latchedCodes, rowPattern(3));
    strobe = 1'b0;
    @(posedge clk); #2;
    expectEq("R4", "outEnable after fall", outEnable, 1);
    expectEq("R5", "highDrive after fall", highDrive, 1);
    expectEq("R10", "protoErr for 2-clock strobe", protoErr, 0);
    expectEq("R8", "polarity 0 assignment", chanPolSel, polPattern(1'b0));
    countWindow(n, 0);
    expectEq("R5", "short window length", n, SHORT_WIN);
    expectEq("R4", "outEnable stays after window", outEnable, 1);
  endtask

  task automatic testLongWindow();
    int n;
    lineData = rowPattern(11); polarity = 1'b1; longDriveN = 1'b0;
    strobe = 1'b1;
    tick();
    polarity = 1'b0;
    tick();
    expectEq("R8", "polarity 1 assignment", chanPolSel, polPattern(1'b1));
    strobe = 1'b0;
    tick();
    expectEq("R8", "late polarity change ignored", chanPolSel, polPattern(1'b1));
    countWindow(n, 2);
    expectEq("R6", "long window length", n, LONG_WIN);
    expectEq("R7", "select flip ignored (window stayed long)", n, LONG_WIN);
    longDriveN = 1'b1;
  endtask

  task automatic testShortStrobe();
    int n;
    lineData = rowPattern(21);
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
    tick();
    expectEq("R10", "protoErr for 1-clock strobe", protoErr, 1);
    expectEq("R2", "codes still transferred", latchedCodes, rowPattern(21));
    countWindow(n, 0);
    strobe = 1'b1;
    tick(); tick();
    strobe = 1'b0;
    tick();
    expectEq("R10", "protoErr cleared by good strobe", protoErr, 0);
    countWindow(n, 0);
  endtask

  task automatic testAbort();
    int n;
    lineData = rowPattern(50);
    strobe = 1'b1; tick(); tick();
    strobe = 1'b0; tick();
    tick();
    expectEq("R9", "window running before abort", highDrive, 1);
    strobe = 1'b1;
    tick();
    expectEq("R9", "highDrive killed by new strobe", highDrive, 0);
    expectEq("R9", "outEnable killed by new strobe", outEnable, 0);
    tick();
    strobe = 1'b0;
    tick();
    countWindow(n, 0);
    expectEq("R5", "full window after abort", n, SHORT_WIN);
  endtask

  task automatic testIdleIgnored();
    logic [DW-1:0] heldCodes;
    logic [NUM_CH-1:0] heldPol;
    heldCodes = latchedCodes;
    heldPol   = chanPolSel;
    for (int k = 0; k < 5; k++) begin
      lineData = rowPattern(60 + k);
      polarity = k[0];
      tick();
    end
    #4;
    expectEq("R11", "codes held while idle", latchedCodes, heldCodes);
    expectEq("R11", "polarity select held while idle", chanPolSel, heldPol);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testShortWindow();
    testLongWindow();
    testShortStrobe();
    testAbort();
    testIdleIgnored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule